// File: doc/BRIEF.md
# Single-Bit Boolean Processor Unit

This execution unit carries out the single-bit operations of a small 8-bit controller datapath. Each request holds a decoded operation code, an 8-bit bit address, a signed 8-bit relative offset and the address of the next instruction. The unit owns a 256-bit addressable bit space. The lower half (bit addresses 00h–7Fh) stands for internal RAM. The upper half (80h–FFh) stands for special-function registers, which include the output ports and the status word. The carry flag serves as the one-bit accumulator. It lives at bit 7 of the status word, so a direct bit write to its address and a write through the carry path reach the same flip-flop.

Requests enter over a valid/ready handshake. The unit holds `op_ready` low while reset is asserted and high after it. It never applies back-pressure after that, because every operation finishes in the cycle it is accepted. One cycle after each accepted request, `done` pulses for one cycle. With that pulse the unit reports the branch decision, the branch target and any bit it wrote. The updated carry and port values can be seen on the same cycle. There is no result-side handshake, so the consumer must take the strobe when it occurs.

Top module: `bitproc_unit`

## Requirements
- R1: While `rst` is high and after its release, all 256 bits read 0, so `carry` is 0, `port_out` is 0 and `done`, `taken` and `wb_en` are 0. `op_ready` is 0 during reset and 1 from the first cycle after it.
- R2: Bit address A selects byte A[7:3] and bit A[2:0] of a 32-byte store. Port byte p (p = 0..3) is the byte at bit address 80h + 10h·p, and it drives `port_out[8p+7:8p]`, with bit address 80h + 10h·p + i on `port_out[8p+i]`.
- R3: The carry is bit address D7h. `carry` always shows that bit. Carry-path writes and direct writes to D7h change the same bit.
- R4: The codes are 0 C=bit, 1 bit=C, 2 set bit, 3 clear bit, 4 complement bit, 5 set C, 6 clear C, 7 complement C.
- R5: The codes are 8 C=C AND bit, 9 C=C AND NOT bit, 10 C=C OR bit, 11 C=C OR NOT bit.
- R6: The codes are 12 jump if C=1, 13 jump if C=0, 14 jump if bit=1, 15 jump if bit=0. `taken` shows the condition, and no bit is written.
- R7: Code 16 (test-and-clear) jumps and clears the bit when the bit is 1. When the bit is 0 it neither jumps nor writes.
- R8: With every `done` pulse, `target` equals `next_pc` plus the sign-extended `rel_off`, modulo 2^16. This covers offsets −128 and +127.
- R9: Codes 17–31 change no bit. They report `taken`=0 and `wb_en`=0, and they still pulse `done`.
- R10: `done` is high exactly in the cycle after each accepted request. `wb_en`, `wb_addr` and `wb_value` report the bit written by that request, where D7h is the address for carry-path writes.
- R11: A bit write changes only the selected bit of its byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Unit accepts a request |
| op_code | input | 5 | Decoded bit operation |
| bit_addr | input | 8 | Direct bit address |
| rel_off | input | 8 | Signed branch offset |
| next_pc | input | 16 | Address after the instruction |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | Branch taken, valid with done |
| target | output | 16 | Branch target, valid with done |
| carry | output | 1 | Current carry flag |
| wb_en | output | 1 | A bit was written, valid with done |
| wb_addr | output | 8 | Address of written bit |
| wb_value | output | 1 | Value written |
| port_out | output | 32 | Four port bytes |

## Verification
The test-and-clear jump makes a branch decision and writes a bit in the same cycle. The bench provokes this by setting a bit and then issuing code 16 on it, with the bit at D7h as the sharpest case. There the tested bit is the carry itself, so `taken` must be 1 while the carry drops to 0 with the same strobe. A second access to that bit then has to see 0. Carry-path and direct-address writes to D7h are also interleaved back to back. Each result is judged against a behavioural bit-array model on every completion.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;
  localparam int BA_W = 8;
  localparam int SPACE_BITS = 2 ** BA_W;
  localparam logic [BA_W-1:0] CARRY_ADDR = 8'hD7;
  localparam int PORT_BASE = 128;
  localparam int PORT_STRIDE = 16;

  typedef enum logic [4:0] {
    OP_MOV_C_B  = 5'd0,
    OP_MOV_B_C  = 5'd1,
    OP_SET_B    = 5'd2,
    OP_CLR_B    = 5'd3,
    OP_CPL_B    = 5'd4,
    OP_SET_C    = 5'd5,
    OP_CLR_C    = 5'd6,
    OP_CPL_C    = 5'd7,
    OP_AND_B    = 5'd8,
    OP_AND_NB   = 5'd9,
    OP_OR_B     = 5'd10,
    OP_OR_NB    = 5'd11,
    OP_JMP_C    = 5'd12,
    OP_JMP_NC   = 5'd13,
    OP_JMP_B    = 5'd14,
    OP_JMP_NB   = 5'd15,
    OP_JMP_BCLR = 5'd16
  } bit_op_e;
endpackage

// File: rtl/bitproc_store.sv
module bitproc_store
  import bitproc_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BA_W-1:0]      rd_addr,
  input  logic                 wr_en,
  input  logic [BA_W-1:0]      wr_addr,
  input  logic                 wr_val,
  output logic                 rd_bit,
  output logic                 carry,
  output logic [N_PORTS*8-1:0] port_bytes
);
  localparam int BYTES = SPACE_BITS / 8;
  localparam int IDX_W = BA_W - 3;

  logic [SPACE_BITS-1:0] space;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic [7:0] q;
    logic       hit;
    logic [7:0] mask;
    assign hit  = wr_en && (wr_addr[BA_W-1:3] == IDX_W'(g));
    assign mask = 8'(1) << wr_addr[2:0];
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit) begin
        q <= wr_val ? (q | mask) : (q & ~mask);
      end
    end
    assign space[g*8 +: 8] = q;
  end

  assign rd_bit = space[rd_addr];
  assign carry  = space[CARRY_ADDR];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign port_bytes[p*8 +: 8] = space[PORT_BASE + p*PORT_STRIDE +: 8];
  end
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
  import bitproc_pkg::*;
(
  input  logic [4:0]      op_code,
  input  logic [BA_W-1:0] bit_addr,
  input  logic            cur_bit,
  input  logic            cur_carry,
  output logic            wr_req,
  output logic [BA_W-1:0] wr_addr,
  output logic            wr_val,
  output logic            cond
);
  always_comb begin
    wr_req  = 1'b0;
    wr_addr = bit_addr;
    wr_val  = 1'b0;
    cond    = 1'b0;
    case (op_code)
      OP_MOV_C_B:  begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = cur_bit; end
      OP_MOV_B_C:  begin wr_req = 1'b1; wr_val = cur_carry; end
      OP_SET_B:    begin wr_req = 1'b1; wr_val = 1'b1; end
      OP_CLR_B:    begin wr_req = 1'b1; wr_val = 1'b0; end
      OP_CPL_B:    begin wr_req = 1'b1; wr_val = ~cur_bit; end
      OP_SET_C:    begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = 1'b1; end
      OP_CLR_C:    begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = 1'b0; end
      OP_CPL_C:    begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = ~cur_carry; end
      OP_AND_B:    begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = cur_carry & cur_bit; end
      OP_AND_NB:   begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = cur_carry & ~cur_bit; end
      OP_OR_B:     begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = cur_carry | cur_bit; end
      OP_OR_NB:    begin wr_req = 1'b1; wr_addr = CARRY_ADDR; wr_val = cur_carry | ~cur_bit; end
      OP_JMP_C:    cond = cur_carry;
      OP_JMP_NC:   cond = ~cur_carry;
      OP_JMP_B:    cond = cur_bit;
      OP_JMP_NB:   cond = ~cur_bit;
      OP_JMP_BCLR: begin cond = cur_bit; wr_req = cur_bit; wr_val = 1'b0; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/bitproc_branch.sv
module bitproc_branch #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  next_pc,
  input  logic [OFF_W-1:0] rel_off,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W;
  logic [PC_W-1:0] off_ext;
  assign off_ext = {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
  assign target  = next_pc + off_ext;
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int N_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [4:0]           op_code,
  input  logic [BA_W-1:0]      bit_addr,
  input  logic [7:0]           rel_off,
  input  logic [PC_W-1:0]      next_pc,
  output logic                 done,
  output logic                 taken,
  output logic [PC_W-1:0]      target,
  output logic                 carry,
  output logic                 wb_en,
  output logic [BA_W-1:0]      wb_addr,
  output logic                 wb_value,
  output logic [N_PORTS*8-1:0] port_out
);
  logic            ready_q;
  logic            accept;
  logic            cur_bit;
  logic            alu_wr;
  logic [BA_W-1:0] alu_addr;
  logic            alu_val;
  logic            alu_cond;
  logic [PC_W-1:0] tgt_next;

  assign op_ready = ready_q;
  assign accept   = op_valid && ready_q;

  always_ff @(posedge clk) begin
    ready_q <= !rst;
  end

  bitproc_store #(.N_PORTS(N_PORTS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd_addr   (bit_addr),
    .wr_en     (accept && alu_wr),
    .wr_addr   (alu_addr),
    .wr_val    (alu_val),
    .rd_bit    (cur_bit),
    .carry     (carry),
    .port_bytes(port_out)
  );

  bitproc_alu u_alu (
    .op_code  (op_code),
    .bit_addr (bit_addr),
    .cur_bit  (cur_bit),
    .cur_carry(carry),
    .wr_req   (alu_wr),
    .wr_addr  (alu_addr),
    .wr_val   (alu_val),
    .cond     (alu_cond)
  );

  bitproc_branch #(.PC_W(PC_W), .OFF_W(8)) u_branch (
    .next_pc(next_pc),
    .rel_off(rel_off),
    .target (tgt_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      taken    <= 1'b0;
      target   <= '0;
      wb_en    <= 1'b0;
      wb_addr  <= '0;
      wb_value <= 1'b0;
    end else begin
      done  <= accept;
      taken <= accept && alu_cond;
      wb_en <= accept && alu_wr;
      if (accept) begin
        target   <= tgt_next;
        wb_addr  <= alu_addr;
        wb_value <= alu_val;
      end
    end
  end
endmodule

// File: rtl/bitproc_checker.sv
module bitproc_checker #(
  parameter int PC_W    = 16,
  parameter int N_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic                 op_ready,
  input logic [4:0]           op_code,
  input logic [7:0]           rel_off,
  input logic [PC_W-1:0]      next_pc,
  input logic                 done,
  input logic                 taken,
  input logic [PC_W-1:0]      target,
  input logic                 carry,
  input logic                 wb_en,
  input logic                 wb_value,
  input logic [N_PORTS*8-1:0] port_out,
  input logic                 cur_bit
);
  localparam int EXT_W = PC_W - 8;
  logic acc;
  assign acc = op_valid && op_ready;

  assert_done_follows_R10: assert property (@(posedge clk) disable iff (rst)
    acc |=> done);
  assert_no_stray_done_R10: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !done);
  assert_taken_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
    taken |-> done);
  assert_target_R8: assert property (@(posedge clk) disable iff (rst)
    acc |=> target == $past(next_pc) + {{EXT_W{$past(rel_off[7])}}, $past(rel_off)});
  assert_unsupported_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code > 5'd16) |=> (!taken && !wb_en && $stable(carry) && $stable(port_out)));
  assert_testclr_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 5'd16 && cur_bit) |=> (taken && wb_en && !wb_value));
  assert_testclr_miss_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 5'd16 && !cur_bit) |=> (!taken && !wb_en));
endmodule

bind bitproc_unit bitproc_checker #(.PC_W(PC_W), .N_PORTS(N_PORTS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_valid(op_valid),
  .op_ready(op_ready),
  .op_code (op_code),
  .rel_off (rel_off),
  .next_pc (next_pc),
  .done    (done),
  .taken   (taken),
  .target  (target),
  .carry   (carry),
  .wb_en   (wb_en),
  .wb_value(wb_value),
  .port_out(port_out),
  .cur_bit (cur_bit)
);

// File: tb/bitproc_unit_tb.sv
`timescale 1ns/1ps
module bitproc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [4:0]  op_code = '0;
  logic [7:0]  bit_addr = '0;
  logic [7:0]  rel_off = '0;
  logic [15:0] next_pc = '0;
  logic        done, taken, carry, wb_en, wb_value;
  logic [15:0] target;
  logic [7:0]  wb_addr;
  logic [31:0] port_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [255:0] ref_v;
  int cyc = 0;

  always #4 clk = ~clk;

  bitproc_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .bit_addr(bit_addr), .rel_off(rel_off), .next_pc(next_pc),
    .done(done), .taken(taken), .target(target), .carry(carry),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_value(wb_value), .port_out(port_out)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_ports();
    logic [31:0] r;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 8; i++) r[p*8+i] = ref_v[128 + 16*p + i];
    return r;
  endfunction

  function automatic string tag_of(int op);
    if (op <= 7) return "R4";
    if (op <= 11) return "R5";
    if (op <= 15) return "R6";
    if (op == 16) return "R7";
    return "R9";
  endfunction

  // Drives one request at a falling edge, checks its completion at the next falling edge.
  task automatic run_op(int op, logic [7:0] a, logic [7:0] off, logic [15:0] npc);
    logic c, b, e_tk, e_we, e_wv;
    logic [7:0] e_wa;
    logic [15:0] e_tg;
    op_valid = 1'b1; op_code = 5'(op); bit_addr = a; rel_off = off; next_pc = npc;
    c = ref_v[8'hD7]; b = ref_v[a];
    e_tk = 0; e_we = 0; e_wa = a; e_wv = 0;
    case (op)
      0: begin e_we = 1; e_wa = 8'hD7; e_wv = b; end
      1: begin e_we = 1; e_wv = c; end
      2: begin e_we = 1; e_wv = 1; end
      3: begin e_we = 1; e_wv = 0; end
      4: begin e_we = 1; e_wv = !b; end
      5: begin e_we = 1; e_wa = 8'hD7; e_wv = 1; end
      6: begin e_we = 1; e_wa = 8'hD7; e_wv = 0; end
      7: begin e_we = 1; e_wa = 8'hD7; e_wv = !c; end
      8: begin e_we = 1; e_wa = 8'hD7; e_wv = c && b; end
      9: begin e_we = 1; e_wa = 8'hD7; e_wv = c && !b; end
      10: begin e_we = 1; e_wa = 8'hD7; e_wv = c || b; end
      11: begin e_we = 1; e_wa = 8'hD7; e_wv = c || !b; end
      12: e_tk = c;
      13: e_tk = !c;
      14: e_tk = b;
      15: e_tk = !b;
      16: begin e_tk = b; e_we = b; e_wv = 0; end
      default: ;
    endcase
    e_tg = npc + {{8{off[7]}}, off};
    if (e_we) ref_v[e_wa] = e_wv;
    @(negedge clk);
    chk({tag_of(op), " R10 done/taken/wb"}, {60'd0, done, taken, wb_en, (wb_en ? wb_value : 1'b0)},
        {60'd0, 1'b1, e_tk, e_we, e_wv});
    if (e_we) chk("R10 wb_addr", {56'd0, wb_addr}, {56'd0, e_wa});
    chk("R8 target", {48'd0, target}, {48'd0, e_tg});
    chk("R3 carry", {63'd0, carry}, {63'd0, ref_v[8'hD7]});
    chk("R2 R11 ports", {32'd0, port_out}, {32'd0, ref_ports()});
  endtask

  task automatic idle();
    op_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle done", {63'd0, done}, 64'd0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        finished = 1;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lf;
    ref_v = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {63'd0, op_ready}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {30'd0, op_ready, done, taken, wb_en, carry, port_out},
        {30'd0, 1'b1, 4'b0000, 32'd0});
    // R4 moves, set/clear/complement
    run_op(2, 8'h80, 8'h00, 16'h0100);
    run_op(2, 8'h93, 8'h00, 16'h0100);
    run_op(4, 8'hB7, 8'h00, 16'h0100);
    run_op(0, 8'h93, 8'h00, 16'h0100);
    run_op(1, 8'hA5, 8'h00, 16'h0100);
    run_op(3, 8'h80, 8'h00, 16'h0100);
    run_op(7, 8'h00, 8'h00, 16'h0100);
    run_op(6, 8'h00, 8'h00, 16'h0100);
    run_op(5, 8'h00, 8'h00, 16'h0100);
    idle();
    // R3 carry through its direct address, back to back with carry path
    run_op(3, 8'hD7, 8'h00, 16'h0200);
    run_op(2, 8'hD7, 8'h00, 16'h0200);
    run_op(6, 8'h00, 8'h00, 16'h0200);
    run_op(4, 8'hD7, 8'h00, 16'h0200);
    run_op(14, 8'hD7, 8'h05, 16'h0200);
    // R11 neighbours in one byte
    run_op(2, 8'h21, 8'h00, 16'h0300);
    run_op(2, 8'h22, 8'h00, 16'h0300);
    run_op(3, 8'h21, 8'h00, 16'h0300);
    run_op(0, 8'h22, 8'h00, 16'h0300);
    run_op(0, 8'h20, 8'h00, 16'h0300);
    // R5 AND/OR with true and inverted operand
    run_op(5, 8'h00, 8'h00, 16'h0400);
    run_op(8, 8'h22, 8'h00, 16'h0400);
    run_op(9, 8'h22, 8'h00, 16'h0400);
    run_op(10, 8'h23, 8'h00, 16'h0400);
    run_op(11, 8'h23, 8'h00, 16'h0400);
    run_op(11, 8'h22, 8'h00, 16'h0400);
    // R6 jumps with R8 offset extremes
    run_op(12, 8'h00, 8'h80, 16'h1000);
    run_op(13, 8'h00, 8'h7F, 16'h1000);
    run_op(14, 8'h22, 8'h7F, 16'hFFF0);
    run_op(15, 8'h22, 8'h80, 16'h0010);
    run_op(15, 8'h23, 8'hFF, 16'h0000);
    // R7 test-and-clear, including the carry bit itself
    run_op(16, 8'h22, 8'h10, 16'h2000);
    run_op(14, 8'h22, 8'h10, 16'h2000);
    run_op(16, 8'h22, 8'h10, 16'h2000);
    run_op(5, 8'h00, 8'h00, 16'h2000);
    run_op(16, 8'hD7, 8'h80, 16'h2000);
    run_op(12, 8'h00, 8'h01, 16'h2000);
    // R9 unsupported codes
    run_op(2, 8'h81, 8'h00, 16'h3000);
    run_op(17, 8'h81, 8'h04, 16'h3000);
    run_op(31, 8'hD7, 8'h04, 16'h3000);
    run_op(24, 8'h81, 8'h04, 16'h3000);
    idle();
    // mixed sequence against the model
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      logic [7:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[9:8])
        2'd0: a = 8'hD7;
        2'd1: a = 8'h80 | {5'd0, lf[2:0]};
        default: a = lf[7:0];
      endcase
      run_op(int'(lf[14:10]) % 20, a, lf[7:0] ^ lf[15:8], lf ^ 16'h5A5A);
      if (lf[0] && lf[3]) idle();
    end
    idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule